// File: doc/BRIEF.md
# Debug Bus Trigger Comparator Matrix

This block detects debug events on a processor's buses. A set of memory trigger units watches each bus cycle. Each unit compares either the address or the data of the cycle with a programmed value, under a mask and with a selectable relation. A unit responds only to the access kinds it is enabled for: read, write, DMA or instruction fetch. A smaller set of register trigger units watches CPU register writes. Each one matches a write to one chosen register index whose value satisfies its own masked relation.

The unit outputs feed an AND matrix. Each combination output fires when every trigger in its selection set fired in the same cycle. A compound event, such as a given value written to a given address, is expressed by selecting one address unit and one data unit. Any combination output can be enabled to raise a halt request, which acts as a hardware breakpoint. All configuration arrives as static input vectors from the surrounding debug logic.

Two elaboration options select the variant. One gives the full set of four relations or only equal and not-equal. The other gives a mask with one bit per data bit or one bit per byte.

Top module: `dtm_trigger_matrix`

## Requirements
- R1: While `rst_n` is low, every unit hit, every combination output and `halt_req` are 0.
- R2: A memory unit compares `bus_addr` when its source bit is 0 and `bus_data` when it is 1.
- R3: In the full variant the 2-bit relation code is 00 equal, 01 not equal, 10 observed >= programmed, 11 observed <= programmed, with unsigned comparison.
- R4: In the reduced variant each unit has a 1-bit relation code: 0 equal, 1 not equal.
- R5: Mask bits that are 0 are cleared on both the observed and the programmed value before the relation is evaluated.
- R6: In the byte-mask variant, mask bit b enables byte lane b (bit 0 is the low byte, bit 1 the high byte of a 16-bit bus).
- R7: A memory unit can hit only when `bus_valid` is 1 and one of its enabled qualifiers is active. The 4-bit qualifier enable is bit 0 read, bit 1 write, bit 2 DMA, bit 3 instruction fetch.
- R8: A register unit hits only when `rw_en` is 1, `rw_idx` equals its programmed index, and `rw_val` satisfies its relation under its per-bit mask.
- R9: Unit hits appear one clock after the sampled cycle. Combination outputs and `halt_req` follow the hits in the same cycle.
- R10: Combination output k fires when its selection is non-empty and every selected trigger hit. Selection bit i below N_MEM picks memory unit i, and bit N_MEM+j picks register unit j. An empty selection never fires.
- R11: `halt_req` is 1 exactly when some combination output with its break enable set fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | W | Address of the current bus cycle |
| bus_data | input | W | Data of the current bus cycle |
| bus_valid | input | 1 | A bus cycle is present |
| bus_rd | input | 1 | Cycle is a read |
| bus_wr | input | 1 | Cycle is a write |
| bus_dma | input | 1 | Cycle is a DMA access |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| rw_en | input | 1 | A CPU register write occurs |
| rw_idx | input | IDX_W | Index of the written register |
| rw_val | input | W | Value written |
| mt_src | input | N_MEM | Per memory unit: 0 address, 1 data |
| mt_rel | input | N_MEM*REL_W | Per memory unit relation code |
| mt_val | input | N_MEM*W | Per memory unit programmed value |
| mt_mask | input | N_MEM*MW | Per memory unit mask (bit or byte lanes) |
| mt_acc | input | N_MEM*4 | Per memory unit qualifier enables |
| rt_idx | input | N_REG*IDX_W | Per register unit register index |
| rt_rel | input | N_REG*REL_W | Per register unit relation code |
| rt_val | input | N_REG*W | Per register unit programmed value |
| rt_mask | input | N_REG*W | Per register unit bit mask |
| ct_sel | input | N_COMB*(N_MEM+N_REG) | Per combination selection set |
| ct_brk | input | N_COMB | Per combination break enable |
| mt_hit | output | N_MEM | Memory unit hits |
| rt_hit | output | N_REG | Register unit hits |
| ct_hit | output | N_COMB | Combination outputs |
| halt_req | output | 1 | Hardware breakpoint request |

## Verification
The bound checker checks on every cycle that each memory hit was preceded by a valid cycle with an enabled qualifier. It checks that each register hit was preceded by a write to the programmed index. It also checks that no combination output fires with an empty selection or with a selected trigger missing, and that a halt always has a break-enabled combination behind it. Only the bench's scenarios can show the value side: the unsigned relation boundaries, masking of high bits, byte-lane masks, and the reduced relation set. They also show the source selection and the one-cycle latency, which the bench compares against its own model on both variants.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
   typedef enum logic [1:0] {
      REL_EQ = 2'b00,
      REL_NE = 2'b01,
      REL_GE = 2'b10,
      REL_LE = 2'b11
   } rel_e;

   localparam int QUAL_W   = 4;
   localparam int QUAL_RD  = 0;
   localparam int QUAL_WR  = 1;
   localparam int QUAL_DMA = 2;
   localparam int QUAL_FCH = 3;
endpackage

// File: rtl/dtm_cmp.sv
module dtm_cmp
   import dtm_pkg::*;
#(
   parameter int W         = 16,
   parameter int MW        = 16,
   parameter int REL_W     = 2,
   parameter bit FULL_REL  = 1'b1,
   parameter bit BYTE_MASK = 1'b0
) (
   input  logic [W-1:0]     obs,
   input  logic [W-1:0]     ref_v,
   input  logic [MW-1:0]    mask,
   input  logic [REL_W-1:0] rel,
   output logic             match
);
   localparam int LANES = W / 8;

   logic [W-1:0] emask;
   logic [W-1:0] mo;
   logic [W-1:0] mr;

   generate
      if (BYTE_MASK) begin : g_byte
         for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign emask[b*8 +: 8] = {8{mask[b]}};
         end
      end else begin : g_bit
         assign emask = mask;
      end
   endgenerate

   assign mo = obs & emask;
   assign mr = ref_v & emask;

   generate
      if (FULL_REL) begin : g_full
         rel_e r;
         assign r = rel_e'(rel);
         always_comb begin
            case (r)
               REL_EQ:  match = (mo == mr);
               REL_NE:  match = (mo != mr);
               REL_GE:  match = (mo >= mr);
               default: match = (mo <= mr);
            endcase
         end
      end else begin : g_min
         assign match = rel[0] ? (mo != mr) : (mo == mr);
      end
   endgenerate
endmodule

// File: rtl/dtm_mem_unit.sv
module dtm_mem_unit
   import dtm_pkg::*;
#(
   parameter int W         = 16,
   parameter int MW        = 16,
   parameter int REL_W     = 2,
   parameter bit FULL_REL  = 1'b1,
   parameter bit BYTE_MASK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      addr,
   input  logic [W-1:0]      data,
   input  logic              valid,
   input  logic [QUAL_W-1:0] qual,
   input  logic              cfg_src,
   input  logic [REL_W-1:0]  cfg_rel,
   input  logic [W-1:0]      cfg_val,
   input  logic [MW-1:0]     cfg_mask,
   input  logic [QUAL_W-1:0] cfg_acc,
   output logic              hit
);
   logic [W-1:0] obs;
   logic         qual_ok;
   logic         match;

   assign obs     = cfg_src ? data : addr;
   assign qual_ok = valid && (|(qual & cfg_acc));

   dtm_cmp #(
      .W(W), .MW(MW), .REL_W(REL_W), .FULL_REL(FULL_REL), .BYTE_MASK(BYTE_MASK)
   ) u_cmp (
      .obs(obs), .ref_v(cfg_val), .mask(cfg_mask), .rel(cfg_rel), .match(match)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= qual_ok && match;
   end
endmodule

// File: rtl/dtm_reg_unit.sv
module dtm_reg_unit
   import dtm_pkg::*;
#(
   parameter int W        = 16,
   parameter int IDX_W    = 4,
   parameter int REL_W    = 2,
   parameter bit FULL_REL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wr_val,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [REL_W-1:0] cfg_rel,
   input  logic [W-1:0]     cfg_val,
   input  logic [W-1:0]     cfg_mask,
   output logic             hit
);
   logic match;

   dtm_cmp #(
      .W(W), .MW(W), .REL_W(REL_W), .FULL_REL(FULL_REL), .BYTE_MASK(1'b0)
   ) u_cmp (
      .obs(wr_val), .ref_v(cfg_val), .mask(cfg_mask), .rel(cfg_rel), .match(match)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= wr_en && (wr_idx == cfg_idx) && match;
   end
endmodule

// File: rtl/dtm_comb_matrix.sv
module dtm_comb_matrix #(
   parameter int NS = 10,
   parameter int NC = 8
) (
   input  logic [NS-1:0]    hits,
   input  logic [NC*NS-1:0] sel,
   input  logic [NC-1:0]    brk,
   output logic [NC-1:0]    comb,
   output logic             halt
);
   generate
      for (genvar k = 0; k < NC; k++) begin : g_comb
         logic [NS-1:0] s;
         assign s       = sel[k*NS +: NS];
         assign comb[k] = (|s) && (&(hits | ~s));
      end
   endgenerate

   assign halt = |(comb & brk);
endmodule

// File: rtl/dtm_trigger_matrix.sv
module dtm_trigger_matrix
   import dtm_pkg::*;
#(
   parameter int W         = 16,
   parameter int N_MEM     = 8,
   parameter int N_REG     = 2,
   parameter int N_COMB    = 8,
   parameter int IDX_W     = 4,
   parameter bit FULL_REL  = 1'b1,
   parameter bit BYTE_MASK = 1'b0,
   localparam int MW       = BYTE_MASK ? (W / 8) : W,
   localparam int REL_W    = FULL_REL ? 2 : 1,
   localparam int NSRC     = N_MEM + N_REG
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [W-1:0]            bus_addr,
   input  logic [W-1:0]            bus_data,
   input  logic                    bus_valid,
   input  logic                    bus_rd,
   input  logic                    bus_wr,
   input  logic                    bus_dma,
   input  logic                    bus_fetch,
   input  logic                    rw_en,
   input  logic [IDX_W-1:0]        rw_idx,
   input  logic [W-1:0]            rw_val,
   input  logic [N_MEM-1:0]        mt_src,
   input  logic [N_MEM*REL_W-1:0]  mt_rel,
   input  logic [N_MEM*W-1:0]      mt_val,
   input  logic [N_MEM*MW-1:0]     mt_mask,
   input  logic [N_MEM*QUAL_W-1:0] mt_acc,
   input  logic [N_REG*IDX_W-1:0]  rt_idx,
   input  logic [N_REG*REL_W-1:0]  rt_rel,
   input  logic [N_REG*W-1:0]      rt_val,
   input  logic [N_REG*W-1:0]      rt_mask,
   input  logic [N_COMB*NSRC-1:0]  ct_sel,
   input  logic [N_COMB-1:0]       ct_brk,
   output logic [N_MEM-1:0]        mt_hit,
   output logic [N_REG-1:0]        rt_hit,
   output logic [N_COMB-1:0]       ct_hit,
   output logic                    halt_req
);
   initial begin
      assert (N_MEM >= 1 && N_MEM <= 8) else $error("N_MEM must be 1..8");
      assert (N_REG >= 1 && N_REG <= 2) else $error("N_REG must be 1..2");
      assert (N_COMB >= 1 && N_COMB <= 8) else $error("N_COMB must be 1..8");
      assert (IDX_W >= 1) else $error("IDX_W must be positive");
      assert (!BYTE_MASK || (W % 8 == 0)) else $error("byte mask needs W multiple of 8");
   end

   logic [QUAL_W-1:0] qual;
   logic [NSRC-1:0]   all_hits;

   assign qual[QUAL_RD]  = bus_rd;
   assign qual[QUAL_WR]  = bus_wr;
   assign qual[QUAL_DMA] = bus_dma;
   assign qual[QUAL_FCH] = bus_fetch;

   generate
      for (genvar i = 0; i < N_MEM; i++) begin : g_mem
         dtm_mem_unit #(
            .W(W), .MW(MW), .REL_W(REL_W), .FULL_REL(FULL_REL), .BYTE_MASK(BYTE_MASK)
         ) u_mem (
            .clk(clk), .rst_n(rst_n),
            .addr(bus_addr), .data(bus_data), .valid(bus_valid), .qual(qual),
            .cfg_src(mt_src[i]),
            .cfg_rel(mt_rel[i*REL_W +: REL_W]),
            .cfg_val(mt_val[i*W +: W]),
            .cfg_mask(mt_mask[i*MW +: MW]),
            .cfg_acc(mt_acc[i*QUAL_W +: QUAL_W]),
            .hit(mt_hit[i])
         );
      end
      for (genvar j = 0; j < N_REG; j++) begin : g_reg
         dtm_reg_unit #(
            .W(W), .IDX_W(IDX_W), .REL_W(REL_W), .FULL_REL(FULL_REL)
         ) u_reg (
            .clk(clk), .rst_n(rst_n),
            .wr_en(rw_en), .wr_idx(rw_idx), .wr_val(rw_val),
            .cfg_idx(rt_idx[j*IDX_W +: IDX_W]),
            .cfg_rel(rt_rel[j*REL_W +: REL_W]),
            .cfg_val(rt_val[j*W +: W]),
            .cfg_mask(rt_mask[j*W +: W]),
            .hit(rt_hit[j])
         );
      end
   endgenerate

   assign all_hits = {rt_hit, mt_hit};

   dtm_comb_matrix #(.NS(NSRC), .NC(N_COMB)) u_matrix (
      .hits(all_hits), .sel(ct_sel), .brk(ct_brk), .comb(ct_hit), .halt(halt_req)
   );
endmodule

// File: rtl/dtm_trigger_matrix_chk.sv
module dtm_trigger_matrix_chk #(
   parameter int N_MEM  = 8,
   parameter int N_REG  = 2,
   parameter int N_COMB = 8,
   parameter int IDX_W  = 4,
   localparam int NSRC  = N_MEM + N_REG
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_valid,
   input logic                   bus_rd,
   input logic                   bus_wr,
   input logic                   bus_dma,
   input logic                   bus_fetch,
   input logic                   rw_en,
   input logic [IDX_W-1:0]       rw_idx,
   input logic [N_MEM*4-1:0]     mt_acc,
   input logic [N_REG*IDX_W-1:0] rt_idx,
   input logic [N_COMB*NSRC-1:0] ct_sel,
   input logic [N_COMB-1:0]      ct_brk,
   input logic [N_MEM-1:0]       mt_hit,
   input logic [N_REG-1:0]       rt_hit,
   input logic [N_COMB-1:0]      ct_hit,
   input logic                   halt_req
);
   logic [3:0]      qual_now;
   logic [NSRC-1:0] hits;

   assign qual_now = {bus_fetch, bus_dma, bus_wr, bus_rd};
   assign hits     = {rt_hit, mt_hit};

   generate
      for (genvar i = 0; i < N_MEM; i++) begin : g_m
         // R7
         mem_hit_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mt_hit[i] |-> $past(bus_valid && (|(qual_now & mt_acc[i*4 +: 4]))));
      end
      for (genvar j = 0; j < N_REG; j++) begin : g_r
         // R8
         reg_hit_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rt_hit[j] |-> $past(rw_en && (rw_idx == rt_idx[j*IDX_W +: IDX_W])));
      end
      for (genvar k = 0; k < N_COMB; k++) begin : g_c
         // R10
         comb_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ct_hit[k] |-> ((hits & ct_sel[k*NSRC +: NSRC]) == ct_sel[k*NSRC +: NSRC]));
         // R10
         comb_empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ct_sel[k*NSRC +: NSRC] == '0) |-> !ct_hit[k]);
      end
   endgenerate

   // R11
   halt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> (|(ct_hit & ct_brk)));
endmodule

bind dtm_trigger_matrix dtm_trigger_matrix_chk #(
   .N_MEM(N_MEM), .N_REG(N_REG), .N_COMB(N_COMB), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_dma(bus_dma), .bus_fetch(bus_fetch), .rw_en(rw_en), .rw_idx(rw_idx),
   .mt_acc(mt_acc), .rt_idx(rt_idx), .ct_sel(ct_sel), .ct_brk(ct_brk),
   .mt_hit(mt_hit), .rt_hit(rt_hit), .ct_hit(ct_hit), .halt_req(halt_req)
);

// File: tb/tb_dtm_trigger_matrix.sv
`timescale 1ns/1ps
module tb_dtm_trigger_matrix;
   localparam int W = 16, N_MEM = 8, N_REG = 2, N_COMB = 8, IDX_W = 4;
   localparam int NSRC = N_MEM + N_REG;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0] bus_addr, bus_data, rw_val;
   logic bus_valid, bus_rd, bus_wr, bus_dma, bus_fetch, rw_en;
   logic [IDX_W-1:0] rw_idx;

   logic        m_src [N_MEM];
   logic [1:0]  m_rel [N_MEM];
   logic [15:0] m_val [N_MEM];
   logic [15:0] m_mask[N_MEM];
   logic [1:0]  m_bm  [N_MEM];
   logic [3:0]  m_acc [N_MEM];
   logic [3:0]  r_idx [N_REG];
   logic [1:0]  r_rel [N_REG];
   logic [15:0] r_val [N_REG];
   logic [15:0] r_mask[N_REG];
   logic [NSRC-1:0] c_sel[N_COMB];
   logic [N_COMB-1:0] c_brk;

   logic [N_MEM-1:0] mt_src;
   logic [N_MEM*2-1:0] mt_rel, lt_mask;
   logic [N_MEM-1:0] lt_rel;
   logic [N_MEM*W-1:0] mt_val, mt_mask;
   logic [N_MEM*4-1:0] mt_acc;
   logic [N_REG*IDX_W-1:0] rt_idx;
   logic [N_REG*2-1:0] rt_rel;
   logic [N_REG-1:0] lr_rel;
   logic [N_REG*W-1:0] rt_val, rt_mask;
   logic [N_COMB*NSRC-1:0] ct_sel;

   always_comb begin
      for (int i = 0; i < N_MEM; i++) begin
         mt_src[i] = m_src[i];
         mt_rel[i*2 +: 2] = m_rel[i];
         lt_rel[i] = m_rel[i][0];
         mt_val[i*W +: W] = m_val[i];
         mt_mask[i*W +: W] = m_mask[i];
         lt_mask[i*2 +: 2] = m_bm[i];
         mt_acc[i*4 +: 4] = m_acc[i];
      end
      for (int j = 0; j < N_REG; j++) begin
         rt_idx[j*IDX_W +: IDX_W] = r_idx[j];
         rt_rel[j*2 +: 2] = r_rel[j];
         lr_rel[j] = r_rel[j][0];
         rt_val[j*W +: W] = r_val[j];
         rt_mask[j*W +: W] = r_mask[j];
      end
      for (int k = 0; k < N_COMB; k++) ct_sel[k*NSRC +: NSRC] = c_sel[k];
   end

   logic [N_MEM-1:0] f_mt, l_mt;
   logic [N_REG-1:0] f_rt, l_rt;
   logic [N_COMB-1:0] f_ct, l_ct;
   logic f_halt, l_halt;

   dtm_trigger_matrix #(.W(W), .N_MEM(N_MEM), .N_REG(N_REG), .N_COMB(N_COMB),
      .IDX_W(IDX_W), .FULL_REL(1'b1), .BYTE_MASK(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_valid(bus_valid), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dma(bus_dma),
      .bus_fetch(bus_fetch), .rw_en(rw_en), .rw_idx(rw_idx), .rw_val(rw_val),
      .mt_src(mt_src), .mt_rel(mt_rel), .mt_val(mt_val), .mt_mask(mt_mask),
      .mt_acc(mt_acc), .rt_idx(rt_idx), .rt_rel(rt_rel), .rt_val(rt_val),
      .rt_mask(rt_mask), .ct_sel(ct_sel), .ct_brk(c_brk),
      .mt_hit(f_mt), .rt_hit(f_rt), .ct_hit(f_ct), .halt_req(f_halt));

   dtm_trigger_matrix #(.W(W), .N_MEM(N_MEM), .N_REG(N_REG), .N_COMB(N_COMB),
      .IDX_W(IDX_W), .FULL_REL(1'b0), .BYTE_MASK(1'b1)) dut_lite (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_valid(bus_valid), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dma(bus_dma),
      .bus_fetch(bus_fetch), .rw_en(rw_en), .rw_idx(rw_idx), .rw_val(rw_val),
      .mt_src(mt_src), .mt_rel(lt_rel), .mt_val(mt_val), .mt_mask(lt_mask),
      .mt_acc(mt_acc), .rt_idx(rt_idx), .rt_rel(lr_rel), .rt_val(rt_val),
      .rt_mask(rt_mask), .ct_sel(ct_sel), .ct_brk(c_brk),
      .mt_hit(l_mt), .rt_hit(l_rt), .ct_hit(l_ct), .halt_req(l_halt));

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got %0h exp %0h", tag, got, exp);
      end
   endtask

   function automatic logic rel_ok(logic [15:0] o, logic [15:0] r, logic [15:0] m,
                                   logic [1:0] rel);
      logic [15:0] a, b;
      a = o & m;
      b = r & m;
      case (rel)
         2'd0: return a == b;
         2'd1: return a != b;
         2'd2: return a >= b;
         default: return a <= b;
      endcase
   endfunction

   function automatic logic mem_exp(int i, bit lite);
      logic [15:0] obs;
      if (!bus_valid || (m_acc[i] & {bus_fetch, bus_dma, bus_wr, bus_rd}) == 4'd0)
         return 1'b0;
      obs = m_src[i] ? bus_data : bus_addr;
      if (lite)
         return rel_ok(obs, m_val[i], {{8{m_bm[i][1]}}, {8{m_bm[i][0]}}}, {1'b0, m_rel[i][0]});
      return rel_ok(obs, m_val[i], m_mask[i], m_rel[i]);
   endfunction

   function automatic logic reg_exp(int j, bit lite);
      if (!rw_en || rw_idx != r_idx[j]) return 1'b0;
      return rel_ok(rw_val, r_val[j], r_mask[j], lite ? {1'b0, r_rel[j][0]} : r_rel[j]);
   endfunction

   function automatic logic [N_COMB-1:0] comb_exp(logic [NSRC-1:0] h);
      logic [N_COMB-1:0] c;
      for (int k = 0; k < N_COMB; k++)
         c[k] = (c_sel[k] != '0) && ((h & c_sel[k]) == c_sel[k]);
      return c;
   endfunction

   // Compare both variants with the model after one clock (R9 latency)
   task automatic model_step();
      logic [N_MEM-1:0] em, lm;
      logic [N_REG-1:0] er, lr;
      logic [N_COMB-1:0] ec, lc;
      for (int i = 0; i < N_MEM; i++) begin
         em[i] = mem_exp(i, 1'b0);
         lm[i] = mem_exp(i, 1'b1);
      end
      for (int j = 0; j < N_REG; j++) begin
         er[j] = reg_exp(j, 1'b0);
         lr[j] = reg_exp(j, 1'b1);
      end
      ec = comb_exp({er, em});
      lc = comb_exp({lr, lm});
      @(negedge clk);
      chk("R2 R3 R5 R7 R9 full mem hits", 32'(f_mt), 32'(em));
      chk("R4 R6 R7 R9 lite mem hits", 32'(l_mt), 32'(lm));
      chk("R8 full reg hits", 32'(f_rt), 32'(er));
      chk("R4 R8 lite reg hits", 32'(l_rt), 32'(lr));
      chk("R10 full comb", 32'(f_ct), 32'(ec));
      chk("R10 lite comb", 32'(l_ct), 32'(lc));
      chk("R11 full halt", 32'(f_halt), 32'(|(ec & c_brk)));
      chk("R11 lite halt", 32'(l_halt), 32'(|(lc & c_brk)));
   endtask

   task automatic rand_cfg();
      for (int i = 0; i < N_MEM; i++) begin
         m_src[i] = 1'($urandom);
         m_rel[i] = 2'($urandom);
         m_val[i] = 16'($urandom);
         m_mask[i] = ($urandom % 2 == 0) ? 16'hFFFF : 16'($urandom);
         m_bm[i] = 2'($urandom);
         m_acc[i] = 4'($urandom);
      end
      for (int j = 0; j < N_REG; j++) begin
         r_idx[j] = 4'($urandom % 4);
         r_rel[j] = 2'($urandom);
         r_val[j] = 16'($urandom);
         r_mask[j] = ($urandom % 2 == 0) ? 16'hFFFF : 16'($urandom);
      end
      for (int k = 0; k < N_COMB; k++) begin
         c_sel[k] = '0;
         for (int n = 0; n < int'($urandom % 3); n++) c_sel[k][$urandom % NSRC] = 1'b1;
         c_brk[k] = 1'($urandom);
      end
   endtask

   task automatic rand_bus();
      bus_addr = ($urandom % 3 == 0) ? m_val[$urandom % N_MEM] : 16'($urandom);
      bus_data = ($urandom % 3 == 0) ? m_val[$urandom % N_MEM] : 16'($urandom);
      bus_valid = ($urandom % 4 != 0);
      bus_rd = 1'($urandom); bus_wr = 1'($urandom);
      bus_dma = 1'($urandom); bus_fetch = 1'($urandom);
      rw_en = 1'($urandom);
      rw_idx = 4'($urandom % 4);
      rw_val = ($urandom % 2 == 0) ? r_val[$urandom % N_REG] : 16'($urandom);
   endtask

   task automatic quiet();
      for (int i = 0; i < N_MEM; i++) begin
         m_src[i] = 1'b0; m_rel[i] = 2'd0; m_val[i] = '0;
         m_mask[i] = 16'hFFFF; m_bm[i] = 2'b11; m_acc[i] = 4'd0;
      end
      for (int j = 0; j < N_REG; j++) begin
         r_idx[j] = '0; r_rel[j] = 2'd0; r_val[j] = '0; r_mask[j] = 16'hFFFF;
      end
      for (int k = 0; k < N_COMB; k++) c_sel[k] = '0;
      c_brk = '0;
      bus_addr = '0; bus_data = '0; bus_valid = 1'b0;
      bus_rd = 1'b0; bus_wr = 1'b0; bus_dma = 1'b0; bus_fetch = 1'b0;
      rw_en = 1'b0; rw_idx = '0; rw_val = '0;
   endtask

   task automatic set_addr(logic [15:0] a);
      bus_addr = a;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      quiet();
      m_acc[0] = 4'hF; bus_valid = 1'b1; bus_rd = 1'b1;
      c_sel[0] = 10'b1; c_brk = '1;
      repeat (3) @(negedge clk);
      // R1 reset state with a hitting stimulus present
      chk("R1 mem hits in reset", 32'(f_mt | l_mt), 0);
      chk("R1 reg hits in reset", 32'(f_rt | l_rt), 0);
      chk("R1 comb in reset", 32'(f_ct | l_ct), 0);
      chk("R1 halt in reset", 32'(f_halt | l_halt), 0);
      rst_n = 1'b1;

      // R2 source select
      quiet(); m_acc[0] = 4'hF; m_val[0] = 16'h1234;
      bus_valid = 1'b1; bus_rd = 1'b1; bus_data = 16'h0000;
      set_addr(16'h1234);
      chk("R2 address source hit", 32'(f_mt[0]), 1);
      chk("R2 lite address source hit", 32'(l_mt[0]), 1);
      m_src[0] = 1'b1; @(negedge clk);
      chk("R2 data source no hit", 32'(f_mt[0]), 0);

      // R3 unsigned relations at the boundary
      m_src[0] = 1'b0; m_val[0] = 16'h8000; m_rel[0] = 2'd2;
      set_addr(16'h7FFF); chk("R3 GE below", 32'(f_mt[0]), 0);
      set_addr(16'h8000); chk("R3 GE equal", 32'(f_mt[0]), 1);
      chk("R4 lite code 0 is equal", 32'(l_mt[0]), 1);
      set_addr(16'hFFFF); chk("R3 GE unsigned top", 32'(f_mt[0]), 1);
      m_rel[0] = 2'd3;
      set_addr(16'hFFFF); chk("R3 LE above", 32'(f_mt[0]), 0);
      set_addr(16'h0000); chk("R3 LE zero", 32'(f_mt[0]), 1);
      chk("R4 lite code 1 is not-equal", 32'(l_mt[0]), 1);
      set_addr(16'h8000); chk("R4 lite not-equal on match", 32'(l_mt[0]), 0);
      m_rel[0] = 2'd1;
      set_addr(16'h8001); chk("R3 NE differs", 32'(f_mt[0]), 1);

      // R5 per-bit mask
      m_rel[0] = 2'd0; m_val[0] = 16'h1234; m_mask[0] = 16'h00FF;
      set_addr(16'hAB34); chk("R5 masked equal", 32'(f_mt[0]), 1);
      m_rel[0] = 2'd2; m_val[0] = 16'h0010;
      set_addr(16'hFF0F); chk("R5 masked GE ignores high bits", 32'(f_mt[0]), 0);

      // R6 byte lanes in the lite variant
      m_rel[0] = 2'd0; m_val[0] = 16'h1234; m_bm[0] = 2'b01;
      set_addr(16'hAB34); chk("R6 low lane only", 32'(l_mt[0]), 1);
      m_bm[0] = 2'b10; @(negedge clk);
      chk("R6 high lane differs", 32'(l_mt[0]), 0);

      // R7 qualifiers
      quiet(); m_val[0] = 16'h0055; bus_addr = 16'h0055; m_acc[0] = 4'b0010;
      bus_valid = 1'b1; bus_rd = 1'b1; @(negedge clk);
      chk("R7 read with write-only enable", 32'(f_mt[0]), 0);
      bus_rd = 1'b0; bus_wr = 1'b1; @(negedge clk);
      chk("R7 write qualifies", 32'(f_mt[0]), 1);
      bus_valid = 1'b0; @(negedge clk);
      chk("R7 no cycle no hit", 32'(f_mt[0]), 0);
      bus_valid = 1'b1; bus_wr = 1'b0; bus_fetch = 1'b1; m_acc[0] = 4'b1000; @(negedge clk);
      chk("R7 fetch qualifies", 32'(f_mt[0]), 1);
      bus_fetch = 1'b0; bus_dma = 1'b1; m_acc[0] = 4'b0100; @(negedge clk);
      chk("R7 DMA qualifies", 32'(f_mt[0]), 1);

      // R8 register writes
      quiet(); r_idx[0] = 4'd5; r_val[0] = 16'hABCD;
      rw_en = 1'b1; rw_idx = 4'd4; rw_val = 16'hABCD; @(negedge clk);
      chk("R8 other register", 32'(f_rt[0]), 0);
      rw_idx = 4'd5; @(negedge clk);
      chk("R8 selected register", 32'(f_rt[0]), 1);
      rw_en = 1'b0; @(negedge clk);
      chk("R8 no write", 32'(f_rt[0]), 0);
      rw_en = 1'b1; r_rel[0] = 2'd2; r_val[0] = 16'h0100; rw_val = 16'h00FF; @(negedge clk);
      chk("R8 GE below", 32'(f_rt[0]), 0);

      // R9 latency, R10 matrix, R11 halt
      quiet(); m_acc[0] = 4'hF; m_val[0] = 16'h0042; bus_addr = 16'h0042;
      r_idx[1] = 4'd3; r_val[1] = 16'h0007;
      c_sel[0] = '0; c_sel[0][0] = 1'b1; c_sel[0][N_MEM+1] = 1'b1;
      c_sel[2] = '0; c_sel[2][0] = 1'b1; c_brk[0] = 1'b1;
      @(negedge clk);
      bus_valid = 1'b1; bus_rd = 1'b1; rw_en = 1'b1; rw_idx = 4'd3; rw_val = 16'h0007;
      #1;
      chk("R9 no hit before the edge", 32'(f_mt[0]), 0);
      @(negedge clk);
      chk("R9 hit one clock later", 32'(f_mt[0]), 1);
      chk("R10 address and register pair", 32'(f_ct[0]), 1);
      chk("R10 empty selection never fires", 32'(f_ct[1]), 0);
      chk("R11 break-enabled combination halts", 32'(f_halt), 1);
      rw_en = 1'b0; @(negedge clk);
      chk("R10 missing register trigger", 32'(f_ct[0]), 0);
      chk("R10 single-source combination", 32'(f_ct[2]), 1);
      chk("R11 no halt without break enable", 32'(f_halt), 0);

      // Random phase against the model
      rand_cfg();
      for (int it = 0; it < 400; it++) begin
         if (it % 8 == 0) rand_cfg();
         rand_bus();
         model_step();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired, got running exp finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule